// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with High-Speed Mode and General-Call Reset

This block sits behind the SCL and SDA pads of a two-wire serial bus slave. It brings both lines into the system clock domain and finds the start, repeated-start and stop conditions. It shifts in the address byte and the data bytes and decides, for each byte, whether to pull SDA low in the acknowledge slot. The block never drives SCL. On SDA it only ever pulls the line low, and only during an acknowledge.

Three kinds of traffic are recognised. A first byte of the form 00001xxx is the high-speed master code. It is never acknowledged, and it raises a mode flag that stays set across repeated starts until the next stop. Pad logic can use this flag to switch its input filters. The general-call address 00h is always acknowledged. If the byte after it is 06h, that byte is acknowledged and a one-cycle full-reset pulse is issued. Any other byte after the general-call address is refused and has no effect. Traffic sent to the block's own write address is acknowledged, and each data byte that follows is presented with a one-cycle valid strobe.

The system clock must run at least eight times faster than the fastest bus clock.

Top module: `twi_hs_slave`

## Requirements
- R1: After reset, `sda_pull_o`, `hs_mode_o`, `gc_reset_o` and `byte_valid_o` are all low.
- R2: A first byte after a start whose upper five bits are 00001 is the high-speed master code, whatever its three low bits are. Its low bit is not read as a read/write flag, and SDA stays released during its ninth clock.
- R3: After the master code, `hs_mode_o` goes high and stays high through any number of repeated starts.
- R4: `hs_mode_o` goes low on the next stop condition, which is SDA rising while SCL is high.
- R5: A first byte of 00h (general-call address) is always acknowledged.
- R6: A byte of 06h after the general-call address is acknowledged. After that byte's ninth SCL falling edge, `gc_reset_o` is high for exactly one system clock. This reset clears `hs_mode_o`, and the block then ignores bus bits until the next start.
- R7: Any byte other than 06h after the general-call address is not acknowledged, and it produces no reset pulse and no strobe.
- R8: A first byte equal to {DEV_ADDR, 0} is acknowledged. Every data byte that follows it, up to the next start or stop, is acknowledged and is strobed once on `byte_valid_o`, with its value on `byte_data_o`, after its ninth clock.
- R9: Any other first byte, including the own address with the read bit set, is not acknowledged. The bytes after it are neither acknowledged nor strobed until the next start or stop.
- R10: A start or stop that arrives in the middle of a byte abandons that byte and restarts bit counting, so a following transfer is received correctly.
- R11: `sda_pull_o` is asserted only while a transfer is active, and only in the acknowledge slot of a byte that is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| hs_mode_o | output | 1 | High-speed mode flag |
| gc_reset_o | output | 1 | One-cycle full-reset pulse from general call |
| byte_valid_o | output | 1 | One-cycle strobe for a received data byte |
| byte_data_o | output | 8 | Received data byte, valid with the strobe |

## Verification
A wrong bit counter or a wrong byte state shows up at the ports within one byte time. It appears as a missing or extra pull-low in the ninth-clock window, or as a strobe that carries the wrong byte. A stuck or wrongly cleared mode flag is visible right after the repeated start or the stop that should have preserved or cleared it. A wrong general-call decision shows up as a reset pulse that is missing, repeated or unexpected, measured in system clocks after the ninth falling edge. The same decision can also be seen in the acknowledge that the master samples.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [BYTE_W-1:0] GC_RESET_BYTE = 8'h06;
  localparam logic [4:0] HS_CODE_PREFIX = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_GC,
    ST_SKIP
  } twi_state_e;

  typedef struct packed {
    logic       ack;
    logic       hs_set;
    logic       strobe;
    logic       gc_rst;
    twi_state_e next;
  } twi_dec_t;

  function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:BYTE_W-5] == HS_CODE_PREFIX;
  endfunction

  function automatic logic is_own_write(input logic [BYTE_W-1:0] b,
                                        input logic [BYTE_W-2:0] addr);
    return b == {addr, 1'b0};
  endfunction

  // Decision taken when a byte completes, given the state it arrived in.
  function automatic twi_dec_t decide(input twi_state_e st,
                                      input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-2:0] addr);
    twi_dec_t d;
    d = '0;
    d.next = ST_SKIP;
    case (st)
      ST_ADDR: begin
        if (is_hs_code(b)) begin
          d.hs_set = 1'b1;
        end else if (b == GC_ADDR_BYTE) begin
          d.ack = 1'b1;
          d.next = ST_GC;
        end else if (is_own_write(b, addr)) begin
          d.ack = 1'b1;
          d.next = ST_DATA;
        end
      end
      ST_DATA: begin
        d.ack = 1'b1;
        d.strobe = 1'b1;
        d.next = ST_DATA;
      end
      ST_GC: begin
        if (b == GC_RESET_BYTE) begin
          d.ack = 1'b1;
          d.gc_rst = 1'b1;
          d.next = ST_IDLE;
        end
      end
      default: d.next = ST_SKIP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_byte_fsm.sv
module twi_byte_fsm
  import twi_pkg::*;
#(
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h2A,
  localparam int CW = $clog2(BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull_o,
  output logic              hs_mode_o,
  output logic              gc_reset_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              ninth_fall,
  output logic              bus_busy,
  output logic [CW-1:0]     bit_cnt
);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);
  localparam logic [CW-1:0] ACK_HIGH = CW'(BYTE_W + 1);

  twi_state_e        state;
  logic [BYTE_W-1:0] shreg;
  twi_dec_t          dec_q;
  logic              byte_done;
  logic              shifting;
  logic [BYTE_W-1:0] next_byte;

  assign bus_busy   = (state != ST_IDLE);
  assign shifting   = bus_busy && scl_rise && (bit_cnt < ACK_SLOT);
  assign byte_done  = shifting && (bit_cnt == LAST_BIT);
  assign ninth_fall = bus_busy && scl_fall && (bit_cnt == ACK_HIGH);
  assign next_byte  = {shreg[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      shreg        <= '0;
      bit_cnt      <= '0;
      dec_q        <= '0;
      sda_pull_o   <= 1'b0;
      hs_mode_o    <= 1'b0;
      gc_reset_o   <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
    end else begin
      gc_reset_o   <= 1'b0;
      byte_valid_o <= 1'b0;
      if (stop_det) begin
        state      <= ST_IDLE;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
        hs_mode_o  <= 1'b0;
      end else if (start_det) begin
        state      <= ST_ADDR;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
      end else if (bus_busy) begin
        if (shifting) begin
          shreg   <= next_byte;
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_rise && bit_cnt == ACK_SLOT) begin
          bit_cnt <= ACK_HIGH;
        end
        if (byte_done) begin
          dec_q <= decide(state, next_byte, DEV_ADDR);
        end
        if (scl_fall && bit_cnt == ACK_SLOT) begin
          sda_pull_o <= dec_q.ack;
        end
        if (ninth_fall) begin
          sda_pull_o   <= 1'b0;
          bit_cnt      <= '0;
          byte_valid_o <= dec_q.strobe;
          if (dec_q.strobe) byte_data_o <= shreg;
          if (dec_q.gc_rst) begin
            gc_reset_o <= 1'b1;
            hs_mode_o  <= 1'b0;
            state      <= ST_IDLE;
            shreg      <= '0;
          end else begin
            state <= dec_q.next;
            if (dec_q.hs_set) hs_mode_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_hs_slave.sv
module twi_hs_slave
  import twi_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [6:0]       DEV_ADDR    = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       hs_mode_o,
  output logic       gc_reset_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o
);
  localparam int CW = $clog2(BYTE_W + 2);

  logic          scl_s, sda_s;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic          ninth_fall, bus_busy;
  logic [CW-1:0] bit_cnt;

  twi_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
  );
  twi_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
  );

  twi_cond_det u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_pull_o(sda_pull_o), .hs_mode_o(hs_mode_o),
    .gc_reset_o(gc_reset_o), .byte_valid_o(byte_valid_o),
    .byte_data_o(byte_data_o), .ninth_fall(ninth_fall),
    .bus_busy(bus_busy), .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/twi_hs_slave_chk.sv
module twi_hs_slave_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_det,
  input logic          stop_det,
  input logic          ninth_fall,
  input logic          bus_busy,
  input logic [CW-1:0] bit_cnt,
  input logic          sda_pull_o,
  input logic          hs_mode_o,
  input logic          gc_reset_o,
  input logic          byte_valid_o
);
  a_r4_stop_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode_o);

  a_r3_hs_kept_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode_o && start_det && !stop_det) |=> hs_mode_o);

  a_r2_no_ack_on_hs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode_o) |-> !sda_pull_o);

  a_r6_gc_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset_o |=> !gc_reset_o);

  a_r6_gc_after_ninth: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset_o |-> $past(ninth_fall));

  a_r6_gc_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset_o |-> (!bus_busy && !hs_mode_o));

  a_r8_valid_after_ninth: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> ($past(ninth_fall) && !gc_reset_o));

  a_r10_start_resync: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (bit_cnt == '0));

  a_r11_pull_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> bus_busy);
endmodule

bind twi_hs_slave twi_hs_slave_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .ninth_fall(ninth_fall), .bus_busy(bus_busy), .bit_cnt(bit_cnt),
  .sda_pull_o(sda_pull_o), .hs_mode_o(hs_mode_o),
  .gc_reset_o(gc_reset_o), .byte_valid_o(byte_valid_o)
);

// File: tb/sim_twi_hs_slave.sv
`timescale 1ns/1ps
module sim_twi_hs_slave;
  localparam int Q = 8;            // system clocks per quarter bus bit
  localparam logic [7:0] OWN_W = 8'h54;   // address 2Ah, write

  typedef struct packed {
    logic [7:0] b1;
    logic [7:0] b2;
    logic       ack1;
    logic       ack2;
    logic       hs;
    logic       gc;
    logic       bv;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h06, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},  // R5 R6
    '{8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R7
    '{8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R7
    '{8'h54, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5},  // R8
    '{8'h55, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R9 read bit
    '{8'h12, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R9
    '{8'h08, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},  // R2 R3
    '{8'h0F, 8'h54, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},  // R2 R3
    '{8'h09, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}   // R2 low bit set
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, hs_mode, gc_reset, byte_valid;
  logic [7:0] byte_data;
  wire  sda_line = sda_m & ~sda_pull;

  int tests = 0;
  int fails = 0;
  int gc_cnt = 0;
  int bv_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_hs_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .hs_mode_o(hs_mode), .gc_reset_o(gc_reset),
    .byte_valid_o(byte_valid), .byte_data_o(byte_data)
  );

  always @(negedge clk) begin
    if (gc_reset) gc_cnt <= gc_cnt + 1;
    if (byte_valid) begin
      bv_cnt <= bv_cnt + 1;
      last_byte <= byte_data;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    ack = ~sda_line;
    wq(1); scl_m = 1'b0; wq(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a1, a2;
    int g0, v0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!sda_pull && !hs_mode && !gc_reset && !byte_valid, "R1 reset outputs",
          {sda_pull, hs_mode, gc_reset, byte_valid}, 0);
    rst_n = 1'b1;
    wq(2);

    foreach (VECS[k]) begin
      g0 = gc_cnt; v0 = bv_cnt;
      bus_start();
      send_byte(VECS[k].b1, a1);
      send_byte(VECS[k].b2, a2);
      wq(1);
      check(a1 == VECS[k].ack1, $sformatf("R2/R5/R8/R9 ack1 vec%0d", k), a1, VECS[k].ack1);
      check(a2 == VECS[k].ack2, $sformatf("R6/R7/R8/R9 ack2 vec%0d", k), a2, VECS[k].ack2);
      check(hs_mode == VECS[k].hs, $sformatf("R3 hs vec%0d", k), hs_mode, VECS[k].hs);
      check(gc_cnt - g0 == int'(VECS[k].gc), $sformatf("R6 gc cycles vec%0d", k),
            gc_cnt - g0, VECS[k].gc);
      check(bv_cnt - v0 == int'(VECS[k].bv), $sformatf("R8 strobes vec%0d", k),
            bv_cnt - v0, VECS[k].bv);
      if (VECS[k].bv)
        check(last_byte == VECS[k].data, $sformatf("R8 data vec%0d", k), last_byte, VECS[k].data);
      bus_stop();
      check(!hs_mode, $sformatf("R4 hs after stop vec%0d", k), hs_mode, 0);
    end

    // R3: flag persists over repeated starts, traffic still works
    bus_start();
    send_byte(8'h0B, a1);
    check(!a1, "R2 master code nack", a1, 0);
    bus_start();
    v0 = bv_cnt;
    send_byte(OWN_W, a1); send_byte(8'h11, a2);
    wq(1);
    check(a1 && a2 && hs_mode, "R3 hs after 1st restart", {a1, a2, hs_mode}, 7);
    check(bv_cnt - v0 == 1 && last_byte == 8'h11, "R8 data in hs", last_byte, 8'h11);
    bus_start();
    send_byte(OWN_W, a1); send_byte(8'h22, a2);
    wq(1);
    check(hs_mode && last_byte == 8'h22, "R3 hs after 2nd restart", {hs_mode, last_byte}, 9'h122);
    bus_stop();
    check(!hs_mode, "R4 stop clears hs", hs_mode, 0);

    // R6: after general-call reset the block ignores bits until a start
    bus_start();
    send_byte(8'h00, a1); send_byte(8'h06, a2);
    v0 = bv_cnt;
    send_byte(OWN_W, a1); send_byte(8'h33, a2);
    wq(1);
    check(!a1 && !a2 && bv_cnt == v0, "R6 idle after reset", {a1, a2}, 0);
    bus_stop();

    // R6: general-call reset clears high-speed flag
    bus_start();
    send_byte(8'h0A, a1);
    bus_start();
    g0 = gc_cnt;
    send_byte(8'h00, a1); send_byte(8'h06, a2);
    wq(1);
    check(!hs_mode && gc_cnt - g0 == 1, "R6 reset clears hs", {hs_mode, 8'(gc_cnt - g0)}, 1);
    bus_stop();

    // R10: start in mid byte
    bus_start();
    send_bits(8'hFF, 5);
    bus_start();
    v0 = bv_cnt;
    send_byte(OWN_W, a1); send_byte(8'h77, a2);
    wq(1);
    check(a1 && a2 && bv_cnt - v0 == 1 && last_byte == 8'h77, "R10 start mid byte",
          last_byte, 8'h77);
    // R10: start in mid data byte
    send_bits(8'h00, 3);
    bus_start();
    send_byte(OWN_W, a1); send_byte(8'h5A, a2);
    wq(1);
    check(a1 && a2 && last_byte == 8'h5A, "R10 start mid data", last_byte, 8'h5A);
    // R10: stop in mid byte
    send_bits(8'hC3, 3);
    bus_stop();
    bus_start();
    send_byte(OWN_W, a1); send_byte(8'h66, a2);
    wq(1);
    check(a1 && a2 && last_byte == 8'h66, "R10 stop mid byte", last_byte, 8'h66);
    bus_stop();

    // R11: SDA idle outside transfers
    wq(2);
    check(!sda_pull, "R11 no pull when idle", sda_pull, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule